// File: doc/BRIEF.md
# Quantized Integer Spiking Neuron Array

This block is a recurrent array of `N` spiking neurons whose membrane values are unsigned `B`-bit integers. Each neuron also has a threshold. A host programs the block through one write port: a signed weight for every ordered pair of neurons, a threshold per neuron, and one leak shift amount `k` shared by all neurons. Every pulse on `start` advances the whole network by one discrete time step. For each neuron the block adds up the weights from the neurons that fired in the previous step. It subtracts a leak equal to the neuron's own membrane value shifted right by `k`, clips the result to the unsigned `B`-bit range and compares it with the threshold. That comparison gives the neuron's bit in the new spike vector. A neuron that fires keeps its membrane value.

One datapath serves the whole array. It reads one weight per clock and walks the matrix row by row, so one step takes `N*N` cycles. A zero weight means the two neurons are not connected. The spike vector is double-buffered, so every neuron in a step sees only the previous step's spikes. Configuration writes use a valid/ready handshake. `cfg_ready` is high only while the array is idle. While a step is running the host must hold its write and may keep `cfg_valid` asserted until `cfg_ready` returns. `start`, `done` and the state outputs are plain level signals.

Top module: `qsnn_array`

## Requirements
- R1: At the end of a step, each neuron i holds V_i(t+1) = clip(V_i(t) − (V_i(t) >> k) + Σ_j w_ij·S_j(t)). The sum uses only the spike vector from before the step. Weights are W-bit two's complement, and an accumulator at least W+log2(N)+1 bits wide holds the sum so it cannot overflow.
- R2: The leak is the membrane value minus the same value shifted right by k. With k=0 the previous membrane value is removed completely. With k ≥ B the previous value is kept whole.
- R3: The updated value saturates. A negative result becomes 0, a result above 2^B−1 becomes 2^B−1, and neither one wraps.
- R4: A neuron fires (its spike bit is 1) when its updated value is greater than or equal to its threshold, equality included. Firing does not reset the membrane value.
- R5: `spikes` changes only in the cycle in which `done` is high. While the array is idle and `start` is low, `membranes` does not change.
- R6: If `start` is sampled high at a clock edge while the array is idle, `done` is high for exactly one cycle, following the edge that comes `N*N` clock edges later.
- R7: A configuration write is accepted at a clock edge when `cfg_valid` and `cfg_ready` are both high. `cfg_sel` chooses what is written:
  - 0: the weight for target neuron `cfg_row` from source neuron `cfg_col`, taken from the low W bits of `cfg_data`.
  - 1: the threshold of neuron `cfg_row`, taken from the low B bits.
  - 2: the leak shift k, taken from the low ceil(log2(B+1)) bits.
  - 3: has no effect.
- R8: During a step `cfg_ready` is low. Any write offered then is not applied, and a `start` pulse then is ignored and produces no second `done`.
- R9: A synchronous reset clears all membrane values, spikes and weights to 0, sets every threshold to 2^B−1 and k to 1, and leaves `done` low and `cfg_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins one time step when the array is idle |
| cfg_valid | input | 1 | A configuration write is offered |
| cfg_ready | output | 1 | High while idle; a write is taken when it is high together with cfg_valid |
| cfg_sel | input | 2 | Write target: 0 weight, 1 threshold, 2 leak shift, 3 none |
| cfg_row | input | max(1,log2 N) | Target neuron |
| cfg_col | input | max(1,log2 N) | Source neuron (weight writes only) |
| cfg_data | input | max(W,B,ceil(log2(B+1))) | Write data, low bits used |
| done | output | 1 | One-cycle pulse at the end of a step |
| spikes | output | N | Spike vector of the latest completed step |
| membranes | output | N*B | Membrane values; neuron i in bits [i*B +: B] |

## Verification
The bench builds the array with N=4, B=4 and W=4. At this size one step takes only 16 cycles, so many steps can be run, and every membrane value from 0 to 15 and every weight from −8 to 7 falls inside the range the bench reaches. That makes both clipping bounds reachable in a single step. Every leak shift from 0 (full leak) up to B (no leak) can be swept over several weight and threshold patterns, and each step is compared against integer arithmetic computed in the bench. The small array also keeps it cheap to check the timing of the `done` pulse exactly, and to check that writes and `start` are refused in the middle of a step.

// File: rtl/qsnn_pkg.sv
package qsnn_pkg;

  // Configuration write targets
  typedef enum logic [1:0] {
    CFG_WEIGHT = 2'd0,
    CFG_THRESH = 2'd1,
    CFG_LEAK   = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_sel_e;

  // Step sequencer state
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } step_state_e;

endpackage

// File: rtl/qsnn_cfg_store.sv
module qsnn_cfg_store #(
  parameter int N  = 16,
  parameter int B  = 8,
  parameter int W  = 8,
  parameter int IW = 4,
  parameter int KW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [IW-1:0]       wr_row,
  input  logic [IW-1:0]       wr_col,
  input  logic [DW-1:0]       wr_data,
  input  logic [IW-1:0]       rd_row,
  input  logic [IW-1:0]       rd_col,
  output logic signed [W-1:0] rd_weight,
  output logic [B-1:0]        rd_thresh,
  output logic [KW-1:0]       leak_k
);
  import qsnn_pkg::*;

  logic [W-1:0]  wgt_q [N][N];
  logic [B-1:0]  thr_q [N];
  logic [KW-1:0] k_q;

  // Weight matrix: one storage row per target neuron
  for (genvar r = 0; r < N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int c = 0; c < N; c++) wgt_q[r][c] <= '0;
      end else if (wr_en && cfg_sel_e'(wr_sel) == CFG_WEIGHT && wr_row == IW'(r)) begin
        wgt_q[r][wr_col] <= wr_data[W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        thr_q[r] <= '1;
      end else if (wr_en && cfg_sel_e'(wr_sel) == CFG_THRESH && wr_row == IW'(r)) begin
        thr_q[r] <= wr_data[B-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q <= KW'(1);
    end else if (wr_en && cfg_sel_e'(wr_sel) == CFG_LEAK) begin
      k_q <= wr_data[KW-1:0];
    end
  end

  assign rd_weight = $signed(wgt_q[rd_row][rd_col]);
  assign rd_thresh = thr_q[rd_row];
  assign leak_k    = k_q;

endmodule

// File: rtl/qsnn_step_ctrl.sv
module qsnn_step_ctrl #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic [IW-1:0] row,
  output logic [IW-1:0] col,
  output logic          row_first,
  output logic          row_last,
  output logic          step_last,
  output logic          done
);
  import qsnn_pkg::*;

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  step_state_e   state_q;
  logic [IW-1:0] row_q, col_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            row_q   <= '0;
            col_q   <= '0;
          end
        end
        ST_RUN: begin
          if (col_q == LAST) begin
            col_q <= '0;
            if (row_q == LAST) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign row       = row_q;
  assign col       = col_q;
  assign row_first = (col_q == '0);
  assign row_last  = busy && (col_q == LAST);
  assign step_last = row_last && (row_q == LAST);
  assign done      = done_q;

endmodule

// File: rtl/qsnn_soma.sv
module qsnn_soma #(
  parameter int B  = 8,
  parameter int W  = 8,
  parameter int IW = 4,
  parameter int KW = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                row_first,
  input  logic [B-1:0]        v_cur,
  input  logic signed [W-1:0] weight,
  input  logic                pre_spike,
  input  logic [KW-1:0]       leak_k,
  input  logic [B-1:0]        thresh,
  output logic [B-1:0]        v_new,
  output logic                s_new
);
  // Accumulator wide enough for N terms of W signed bits
  localparam int AW = W + IW + 1;
  // Sum of leaked state and accumulator, signed, with headroom
  localparam int SW = (((B + 1) > AW) ? (B + 1) : AW) + 1;
  localparam logic signed [SW-1:0] VMAX = SW'((1 << B) - 1);

  logic signed [AW-1:0] acc_q, acc_sum, term;
  logic [B-1:0]         leaked;
  logic signed [SW-1:0] total;

  assign term    = pre_spike ? AW'(weight) : '0;
  assign acc_sum = (row_first ? '0 : acc_q) + term;

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_sum;
  end

  // Shift-based leak: subtract the state shifted right by k
  assign leaked = v_cur - (v_cur >> leak_k);
  assign total  = $signed(SW'(leaked)) + SW'(acc_sum);

  always_comb begin
    if (total < 0)         v_new = '0;
    else if (total > VMAX) v_new = '1;
    else                   v_new = total[B-1:0];
  end

  assign s_new = (v_new >= thresh);

endmodule

// File: rtl/qsnn_array.sv
module qsnn_array #(
  parameter int N = 16,
  parameter int B = 8,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int KW = (B > 1) ? $clog2(B + 1) : 1,
  localparam int DW0 = (W > B) ? W : B,
  localparam int DW = (DW0 > KW) ? DW0 : KW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cfg_valid,
  output logic          cfg_ready,
  input  logic [1:0]    cfg_sel,
  input  logic [IW-1:0] cfg_row,
  input  logic [IW-1:0] cfg_col,
  input  logic [DW-1:0] cfg_data,
  output logic          done,
  output logic [N-1:0]  spikes,
  output logic [N*B-1:0] membranes
);

  logic                busy, row_first, row_last, step_last;
  logic [IW-1:0]       row, col;
  logic signed [W-1:0] weight;
  logic [B-1:0]        thresh;
  logic [KW-1:0]       leak_k;
  logic [B-1:0]        v_new;
  logic                s_new;
  logic                wr_en;

  logic [B-1:0] mem_q [N];
  logic [N-1:0] spk_cur_q, spk_nxt_q, spk_merge;

  assign cfg_ready = !busy;
  assign wr_en     = cfg_valid && cfg_ready;

  qsnn_cfg_store #(
    .N(N), .B(B), .W(W), .IW(IW), .KW(KW), .DW(DW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (cfg_sel),
    .wr_row    (cfg_row),
    .wr_col    (cfg_col),
    .wr_data   (cfg_data),
    .rd_row    (row),
    .rd_col    (col),
    .rd_weight (weight),
    .rd_thresh (thresh),
    .leak_k    (leak_k)
  );

  qsnn_step_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .row       (row),
    .col       (col),
    .row_first (row_first),
    .row_last  (row_last),
    .step_last (step_last),
    .done      (done)
  );

  qsnn_soma #(.B(B), .W(W), .IW(IW), .KW(KW)) u_soma (
    .clk       (clk),
    .rst       (rst),
    .en        (busy),
    .row_first (row_first),
    .v_cur     (mem_q[row]),
    .weight    (weight),
    .pre_spike (spk_cur_q[col]),
    .leak_k    (leak_k),
    .thresh    (thresh),
    .v_new     (v_new),
    .s_new     (s_new)
  );

  // New spike vector including the row committed this cycle
  always_comb begin
    spk_merge      = spk_nxt_q;
    spk_merge[row] = s_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem_q[i] <= '0;
      spk_cur_q <= '0;
      spk_nxt_q <= '0;
    end else if (row_last) begin
      mem_q[row]     <= v_new;
      spk_nxt_q[row] <= s_new;
      if (step_last) spk_cur_q <= spk_merge;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_out
    assign membranes[g*B +: B] = mem_q[g];
  end

  assign spikes = spk_cur_q;

endmodule

// File: rtl/qsnn_array_chk.sv
module qsnn_array_chk #(
  parameter int N = 16,
  parameter int B = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           cfg_ready,
  input logic           done,
  input logic [N-1:0]   spikes,
  input logic [N*B-1:0] membranes
);

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !$past(cfg_ready));

  p_spikes_at_done_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(spikes) |-> done);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_ready && !start) |=> $stable(membranes));

  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_ready) |=> !cfg_ready);

endmodule

bind qsnn_array qsnn_array_chk #(.N(N), .B(B)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cfg_ready (cfg_ready),
  .done      (done),
  .spikes    (spikes),
  .membranes (membranes)
);

// File: tb/qsnn_array_bench.sv
module qsnn_array_bench;
  localparam int N  = 4;
  localparam int B  = 4;
  localparam int W  = 4;
  localparam int IW = 2;
  localparam int DW = 4;
  localparam int VMAX = (1 << B) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_ready;
  logic [1:0] cfg_sel = '0;
  logic [IW-1:0] cfg_row = '0, cfg_col = '0;
  logic [DW-1:0] cfg_data = '0;
  logic done;
  logic [N-1:0] spikes;
  logic [N*B-1:0] membranes;

  always #4 clk = ~clk;  // 125 MHz

  qsnn_array #(.N(N), .B(B), .W(W)) u_qsnn_array (
    .clk(clk), .rst(rst), .start(start),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_sel(cfg_sel),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_data(cfg_data),
    .done(done), .spikes(spikes), .membranes(membranes)
  );

  int tests = 0;
  int fails = 0;

  // Behavioural integer model
  int wm [N][N];
  int th_m [N];
  int k_m;
  int mv [N];
  int sp [N];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mem_of(input int i);
    return int'(membranes[i*B +: B]);
  endfunction

  task automatic model_step();
    int nv [N];
    int ns [N];
    for (int i = 0; i < N; i++) begin
      int s;
      s = 0;
      for (int j = 0; j < N; j++) if (sp[j] != 0) s += wm[i][j];
      s += mv[i] - (mv[i] >> k_m);
      if (s < 0) s = 0;
      if (s > VMAX) s = VMAX;
      nv[i] = s;
      ns[i] = (s >= th_m[i]) ? 1 : 0;
    end
    for (int i = 0; i < N; i++) begin
      mv[i] = nv[i];
      sp[i] = ns[i];
    end
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < N; i++) begin
      check(mem_of(i) == mv[i], {tag, " membrane"}, mem_of(i), mv[i]);
      check(int'(spikes[i]) == sp[i], {tag, " spike"}, int'(spikes[i]), sp[i]);
    end
  endtask

  // Entered and left at a negative clock edge
  task automatic cfg_write(input int sel, input int row, input int col, input int data);
    check(cfg_ready == 1'b1, "R7 ready when idle", int'(cfg_ready), 1);
    cfg_valid = 1'b1;
    cfg_sel   = 2'(sel);
    cfg_row   = IW'(row);
    cfg_col   = IW'(col);
    cfg_data  = DW'(data);
    @(negedge clk);
    cfg_valid = 1'b0;
    if (sel == 0) wm[row][col] = data;
    else if (sel == 1) th_m[row] = data;
    else if (sel == 2) k_m = data;
  endtask

  task automatic run_step(input string tag);
    logic [N-1:0] held;
    bit moved;
    int cyc;
    held  = spikes;
    moved = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      if (spikes != held) moved = 1'b1;
      @(negedge clk);
      cyc++;
    end
    check(cyc == N * N, "R6 done latency", cyc, N * N);
    check(!moved, "R5 spikes held during step", int'(moved), 0);
    model_step();
    compare_all(tag);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) wm[i][j] = 0;
      th_m[i] = VMAX;
      mv[i] = 0;
      sp[i] = 0;
    end
    k_m = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    check(done == 1'b0, "R9 done after reset", int'(done), 0);
    check(cfg_ready == 1'b1, "R9 ready after reset", int'(cfg_ready), 1);
    check(spikes == '0, "R9 spikes after reset", int'(spikes), 0);
    check(membranes == '0, "R9 membranes after reset", int'(membranes), 0);
    run_step("R9 default weights and thresholds");

    // R4: equality fires
    cfg_write(1, 0, 0, 0);
    run_step("R4 threshold equality");
    check(spikes[0] == 1'b1, "R4 fire at V==th", int'(spikes[0]), 1);

    // R3: upper saturation; no leak (k >= B)
    cfg_write(2, 0, 0, 7);
    for (int i = 0; i < N; i++) begin
      cfg_write(1, i, 0, 0);
      for (int j = 0; j < N; j++) cfg_write(0, i, j, 7);
    end
    for (int s = 0; s < 3; s++) run_step("R3 upper saturation");
    for (int i = 0; i < N; i++) check(mem_of(i) == VMAX, "R3 clip at max", mem_of(i), VMAX);

    // R4: no reset after firing
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cfg_write(0, i, j, 0);
    run_step("R4 no reset");
    check(mem_of(1) == VMAX && spikes[1], "R4 value kept after spike", mem_of(1), VMAX);

    // R2: partial leak with k=2: 15 - 3 = 12
    cfg_write(2, 0, 0, 2);
    run_step("R2 leak k=2");
    check(mem_of(2) == 12, "R2 leak k=2 value", mem_of(2), 12);

    // R2: k=0 removes state completely
    cfg_write(2, 0, 0, 0);
    run_step("R2 leak k=0");
    check(mem_of(0) == 0, "R2 full leak k=0", mem_of(0), 0);

    // R3: lower saturation
    cfg_write(2, 0, 0, 4);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cfg_write(0, i, j, 7);
    run_step("R3 refill");
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cfg_write(0, i, j, -8);
    run_step("R3 lower saturation");
    for (int i = 0; i < N; i++) check(mem_of(i) == 0, "R3 clip at zero", mem_of(i), 0);

    // R7: select code 3 has no effect
    cfg_write(3, 1, 1, 5);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) cfg_write(0, i, j, (i == j) ? 3 : 0);
    run_step("R7 ignored select");
    run_step("R7 ignored select follow-up");

    // R8: writes and start refused while busy
    begin
      int cyc;
      int extra;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      check(cfg_ready == 1'b0, "R8 ready low while busy", int'(cfg_ready), 0);
      cfg_valid = 1'b1;
      cfg_sel   = 2'd1;
      cfg_row   = '0;
      cfg_data  = '1;
      start     = 1'b1;
      @(negedge clk);
      cfg_sel   = 2'd0;
      cfg_data  = 4'd7;
      @(negedge clk);
      cfg_valid = 1'b0;
      start     = 1'b0;
      cyc = 6;
      while (!done && cyc < 1000) begin
        @(negedge clk);
        cyc++;
      end
      check(cyc == N * N, "R8 step length unchanged", cyc, N * N);
      model_step();
      compare_all("R8 busy step");
      extra = 0;
      repeat (20) begin
        @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R8 start while busy ignored", extra, 0);
      run_step("R8 write while busy not applied");
    end

    // R1: sweep over weight patterns, thresholds and leak shifts
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < N; i++) begin
        cfg_write(1, i, 0, $urandom_range(VMAX, 0));
        for (int j = 0; j < N; j++)
          cfg_write(0, i, j, ($urandom_range(1, 0) == 1) ? 0 : int'($urandom_range(15, 0)) - 8);
      end
      cfg_write(1, p % N, 0, 0);
      for (int k = 0; k <= B; k++) begin
        cfg_write(2, 0, 0, k);
        for (int s = 0; s < 4; s++) run_step("R1 sweep");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule